// File: doc/BRIEF.md
# Card Command Issue Unit

This unit sits between a register write port and a memory-card responder. Software loads a 32-bit argument and then writes a command word. When that word carries the enable bit and not the pending bit, the unit offers one request to the card side. The request holds the command index, the argument and a flag that says whether a reply is expected. The unit then takes one reply beat. The beat holds a byte count, up to sixteen reply bytes and a failure flag.

The unit checks the reply length against what the command asked for. It packs the bytes into four 32-bit words with the most significant byte first. It then sets one of three sticky status flags: reply received, command sent without reply, or timeout. A length mismatch of any kind is reported as a timeout; there is no separate length-error flag.

Both card-side channels are valid/ready:
- A request, once offered, stays valid with a frozen payload until the responder raises `req_ready`.
- The unit raises `rsp_ready` only between acceptance of its request and the reply beat. It takes exactly one beat per command.
- A reply beat offered at any other time is neither consumed nor acted on.

Top module: `card_cmd_issuer`

## Requirements
- R1: After reset the following all read zero: argument, command word, status, the four reply words, `busy`, `req_valid` and `rsp_ready`.
- R2: The register write port decodes `wr_addr` as follows. Address 0 loads the 32-bit argument. Address 1 loads the 11-bit command word: bits 5:0 index, bit 6 reply expected, bit 7 long reply, bit 8 interrupt-mode flag, bit 9 pending, bit 10 enable. Address 2 clears each status bit written as one.
- R3: A command write with bit 10 set and bit 9 clear raises `busy` and `req_valid` at the next edge. The request carries index, argument and bit 6. `req_valid` and its payload hold steady until `req_ready` is seen. Bit 8 does not change this behaviour.
- R4: A command write with bits 10 and 9 both set issues no request and leaves `busy` low. The stored command word reads back with bit 10 cleared.
- R5: While `busy` is high, writes to the argument and command addresses are ignored.
- R6: `rsp_ready` is high only after the request handshake and until the reply beat is taken. A reply beat offered while the unit is idle changes neither status nor reply words.
- R7: For an accepted 4-byte reply, word 0 is reply bytes 0..3 with byte 0 in bits 31:24, words 1..3 become zero, and status bit 6 is set. Reply byte i arrives on `rsp_bytes[8i+7:8i]`.
- R8: For an accepted 16-byte reply, word k is bytes 4k..4k+3 with the lowest-numbered byte most significant, and bit 0 of word 3 is forced to zero. Status bit 6 is set. A 16-byte reply is accepted even when bit 7 asked for a short one.
- R9: Status bit 2 (timeout) is set, with the reply words left unchanged, in any of these cases:
  - `rsp_fail` is high;
  - a reply was expected and the count is 0;
  - a reply was expected and the count is 4 while bit 7 requested a long reply;
  - a reply was expected and the count is neither 4 nor 16.
- R10: A command with bit 6 clear and no failure sets status bit 7 (sent). The reply words are left unchanged whatever count comes back.
- R11: At the edge that takes the reply beat, `busy` falls and bit 10 of the command word clears. The status and reply words update at that same edge.
- R12: Status bits are sticky. Only a clear write removes them, and a clear affects only the bits written as one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 argument, 1 command, 2 status clear |
| wr_data | input | 32 | Register write data |
| arg_q | output | 32 | Stored argument |
| cmd_q | output | 11 | Stored command word |
| busy | output | 1 | Command in flight |
| status_q | output | 8 | Sticky status: bit 2 timeout, bit 6 reply received, bit 7 sent |
| resp_words | output | 128 | Reply word k on bits 32k+31:32k |
| req_valid | output | 1 | Request offered to the card |
| req_ready | input | 1 | Card accepts the request |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| req_resp_exp | output | 1 | Reply expected |
| rsp_valid | input | 1 | Reply beat offered |
| rsp_ready | output | 1 | Unit accepts a reply beat |
| rsp_count | input | 5 | Reply byte count |
| rsp_fail | input | 1 | Card reports failure |
| rsp_bytes | input | 128 | Reply bytes, byte i on bits 8i+7:8i |

## Verification
The assertions watch the following on every cycle:
- a stalled request keeps its valid and payload;
- the argument cannot change while busy;
- a pending-mode write never raises busy;
- the reply channel opens only after a request handshake;
- each reply beat yields at most one outcome flag, and status bits rise only at that beat;
- reply words hold still whenever no good reply is taken;
- bit 0 of word 3 is low after any long reply;
- completion always clears busy and the enable bit.

Only the bench scenarios can show the actual byte-to-word order, the exact status value for each reply-length case, and the ignored writes seen at the ports. They also cover a partial status clear and a stray reply beat offered while idle.

// File: rtl/cciu_pkg.sv
package cciu_pkg;

  localparam int CMD_W     = 11;
  localparam int IDX_W     = 6;
  localparam int B_RESP    = 6;
  localparam int B_LONG    = 7;
  localparam int B_INTR    = 8;
  localparam int B_PEND    = 9;
  localparam int B_EN      = 10;

  localparam int STAT_W    = 8;
  localparam int S_TIMEOUT = 2;
  localparam int S_GOTRESP = 6;
  localparam int S_SENT    = 7;

  localparam logic [1:0] A_ARG = 2'd0;
  localparam logic [1:0] A_CMD = 2'd1;
  localparam logic [1:0] A_CLR = 2'd2;

  typedef enum logic [1:0] {
    LNK_IDLE = 2'd0,
    LNK_REQ  = 2'd1,
    LNK_WAIT = 2'd2
  } link_state_t;

endpackage

// File: rtl/cciu_regs.sv
module cciu_regs
  import cciu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              done,
  output logic [DATA_W-1:0] arg_q,
  output logic [CMD_W-1:0]  cmd_q,
  output logic              busy,
  output logic              start
);

  logic arg_wr, cmd_wr, pend_drop;

  assign arg_wr    = wr_en && (wr_addr == A_ARG) && !busy;
  assign cmd_wr    = wr_en && (wr_addr == A_CMD) && !busy;
  assign start     = cmd_wr && wr_data[B_EN] && !wr_data[B_PEND];
  assign pend_drop = cmd_wr && wr_data[B_EN] && wr_data[B_PEND];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q <= '0;
      cmd_q <= '0;
      busy  <= 1'b0;
    end else begin
      if (arg_wr) arg_q <= wr_data;
      if (cmd_wr) begin
        cmd_q       <= wr_data[CMD_W-1:0];
        cmd_q[B_EN] <= start;
      end else if (done) begin
        cmd_q[B_EN] <= 1'b0;
      end
      if (start)     busy <= 1'b1;
      else if (done) busy <= 1'b0;
    end
  end

  AST_PEND_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_drop |=> (!busy && !cmd_q[B_EN])); // R4

  AST_ARG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(arg_q)); // R5

endmodule

// File: rtl/cciu_link.sv
module cciu_link
  import cciu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic req_valid,
  output logic rsp_ready,
  output logic rsp_fire
);

  link_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      LNK_IDLE: if (start)     state_nx = LNK_REQ;
      LNK_REQ:  if (req_ready) state_nx = LNK_WAIT;
      LNK_WAIT: if (rsp_valid) state_nx = LNK_IDLE;
      default:                 state_nx = LNK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LNK_IDLE;
    else        state <= state_nx;
  end

  assign req_valid = (state == LNK_REQ);
  assign rsp_ready = (state == LNK_WAIT);
  assign rsp_fire  = rsp_valid && rsp_ready;

  AST_REQ_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid); // R3

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_ready) |-> $past(req_valid && req_ready)); // R6

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (state == LNK_IDLE)); // R5

endmodule

// File: rtl/cciu_resp.sv
module cciu_resp
  import cciu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int COUNT_W   = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rsp_fire,
  input  logic                          resp_exp,
  input  logic                          long_req,
  input  logic [COUNT_W-1:0]            rsp_count,
  input  logic                          rsp_fail,
  input  logic [NUM_WORDS*DATA_W-1:0]   rsp_bytes,
  input  logic                          clr_en,
  input  logic [STAT_W-1:0]             clr_mask,
  output logic [NUM_WORDS*DATA_W-1:0]   resp_words,
  output logic [STAT_W-1:0]             status_q
);

  localparam int BPW    = DATA_W / 8;
  localparam int ALL_W  = NUM_WORDS * DATA_W;
  localparam int LAST_LSB = (NUM_WORDS - 1) * DATA_W;
  localparam logic [COUNT_W-1:0] SHORT_CNT = COUNT_W'(BPW);
  localparam logic [COUNT_W-1:0] LONG_CNT  = COUNT_W'(BPW * NUM_WORDS);

  logic [ALL_W-1:0]  packed_be;
  logic [ALL_W-1:0]  next_words;
  logic              bad_len, to_hit, got_hit, sent_hit;
  logic [STAT_W-1:0] set_vec, clr_vec;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    for (genvar j = 0; j < BPW; j++) begin : g_byte
      assign packed_be[k*DATA_W + DATA_W - 8 - 8*j +: 8] =
        rsp_bytes[(k*BPW + j)*8 +: 8];
    end
  end

  always_comb begin
    next_words = packed_be;
    if (rsp_count == SHORT_CNT) next_words[ALL_W-1:DATA_W] = '0;
    else                        next_words[LAST_LSB]       = 1'b0;
  end

  assign bad_len  = (rsp_count == '0)
                 || ((rsp_count == SHORT_CNT) && long_req)
                 || ((rsp_count != SHORT_CNT) && (rsp_count != LONG_CNT));
  assign to_hit   = rsp_fail || (resp_exp && bad_len);
  assign got_hit  = resp_exp && !to_hit;
  assign sent_hit = !resp_exp && !to_hit;

  always_comb begin
    set_vec = '0;
    if (rsp_fire) begin
      set_vec[S_TIMEOUT] = to_hit;
      set_vec[S_GOTRESP] = got_hit;
      set_vec[S_SENT]    = sent_hit;
    end
  end

  assign clr_vec = clr_en ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_words <= '0;
      status_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_vec;
      if (rsp_fire && got_hit) resp_words <= next_words;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec)); // R9

  AST_LONG_LSB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && got_hit && (rsp_count == LONG_CNT)) |=> !resp_words[LAST_LSB]); // R8

  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_fire && got_hit) |=> $stable(resp_words)); // R10

  AST_STATUS_RISE_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fire |=> ((status_q & ~$past(status_q)) == '0)); // R12

endmodule

// File: rtl/card_cmd_issuer.sv
module card_cmd_issuer
  import cciu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int COUNT_W   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [DATA_W-1:0]           arg_q,
  output logic [CMD_W-1:0]            cmd_q,
  output logic                        busy,
  output logic [STAT_W-1:0]           status_q,
  output logic [NUM_WORDS*DATA_W-1:0] resp_words,
  output logic                        req_valid,
  input  logic                        req_ready,
  output logic [IDX_W-1:0]            req_index,
  output logic [DATA_W-1:0]           req_arg,
  output logic                        req_resp_exp,
  input  logic                        rsp_valid,
  output logic                        rsp_ready,
  input  logic [COUNT_W-1:0]          rsp_count,
  input  logic                        rsp_fail,
  input  logic [NUM_WORDS*DATA_W-1:0] rsp_bytes
);

  logic start, rsp_fire, clr_en;

  assign clr_en = wr_en && (wr_addr == A_CLR);

  cciu_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .done    (rsp_fire),
    .arg_q   (arg_q),
    .cmd_q   (cmd_q),
    .busy    (busy),
    .start   (start)
  );

  cciu_link u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .req_valid (req_valid),
    .rsp_ready (rsp_ready),
    .rsp_fire  (rsp_fire)
  );

  cciu_resp #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .COUNT_W(COUNT_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsp_fire   (rsp_fire),
    .resp_exp   (cmd_q[B_RESP]),
    .long_req   (cmd_q[B_LONG]),
    .rsp_count  (rsp_count),
    .rsp_fail   (rsp_fail),
    .rsp_bytes  (rsp_bytes),
    .clr_en     (clr_en),
    .clr_mask   (wr_data[STAT_W-1:0]),
    .resp_words (resp_words),
    .status_q   (status_q)
  );

  assign req_index    = cmd_q[IDX_W-1:0];
  assign req_arg      = arg_q;
  assign req_resp_exp = cmd_q[B_RESP];

  AST_DONE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> (!busy && !cmd_q[B_EN])); // R11

  AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> ($stable(req_index) && $stable(req_arg) && $stable(req_resp_exp))); // R3

endmodule

// File: tb/tb_card_cmd_issuer.sv
`timescale 1ns/1ps
module tb_card_cmd_issuer;

  localparam int WD_CYCLES = 20000;
  localparam int NV = 12;
  // {cmd[10:0], count[4:0], fail, seed[7:0], expected status[7:0]}
  localparam logic [32:0] VEC [NV] = '{
    {11'h442, 5'd4,  1'b0, 8'h11, 8'h40},  // R7 short reply
    {11'h4C9, 5'd16, 1'b0, 8'h23, 8'h40},  // R8 long reply
    {11'h400, 5'd0,  1'b0, 8'h35, 8'h80},  // R10 no reply expected
    {11'h443, 5'd0,  1'b0, 8'h47, 8'h04},  // R9 zero count
    {11'h4C4, 5'd4,  1'b0, 8'h59, 8'h04},  // R9 short given, long asked
    {11'h445, 5'd7,  1'b0, 8'h6B, 8'h04},  // R9 odd count
    {11'h446, 5'd16, 1'b0, 8'h7D, 8'h40},  // R8 long accepted on short ask
    {11'h447, 5'd4,  1'b1, 8'h8F, 8'h04},  // R9 card failure
    {11'h408, 5'd0,  1'b1, 8'hA1, 8'h04},  // R9 failure without reply
    {11'h54A, 5'd4,  1'b0, 8'hB3, 8'h40},  // R3 interrupt flag no effect
    {11'h4CB, 5'd20, 1'b0, 8'hC5, 8'h04},  // R9 over-long count
    {11'h40C, 5'd16, 1'b0, 8'hD7, 8'h80}   // R10 words kept
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [31:0]  arg_q;
  logic [10:0]  cmd_q;
  logic         busy;
  logic [7:0]   status_q;
  logic [127:0] resp_words;
  logic         req_valid;
  logic         req_ready = 1'b1;
  logic [5:0]   req_index;
  logic [31:0]  req_arg;
  logic         req_resp_exp;
  logic         rsp_valid = 1'b0;
  logic         rsp_ready;
  logic [4:0]   rsp_count = '0;
  logic         rsp_fail = 1'b0;
  logic [127:0] rsp_bytes = '0;

  int n_checks = 0;
  int n_fails  = 0;
  logic [127:0] model_words = '0;

  always #5 clk = ~clk;

  card_cmd_issuer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .arg_q(arg_q), .cmd_q(cmd_q), .busy(busy), .status_q(status_q),
    .resp_words(resp_words), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_arg(req_arg), .req_resp_exp(req_resp_exp),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_count(rsp_count),
    .rsp_fail(rsp_fail), .rsp_bytes(rsp_bytes)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] make_bytes(input logic [7:0] seed);
    logic [127:0] b;
    for (int i = 0; i < 16; i++) b[8*i +: 8] = seed + 8'(i * 29) + 8'(i);
    return b;
  endfunction

  // Expected words: byte 4k lands in bits 31:24 of word k
  function automatic logic [127:0] expect_words(input logic [127:0] b, input logic [4:0] cnt);
    logic [127:0] w;
    w = '0;
    for (int k = 0; k < 4; k++)
      w[32*k +: 32] = {b[8*(4*k) +: 8], b[8*(4*k+1) +: 8], b[8*(4*k+2) +: 8], b[8*(4*k+3) +: 8]};
    if (cnt == 5'd4) w[127:32] = '0;
    else             w[96] = 1'b0;
    return w;
  endfunction

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Serve the request currently offered and return one reply beat
  task automatic serve(input logic [10:0] cmd, input logic [31:0] arg,
                       input logic [4:0] cnt, input logic fail, input logic [127:0] b);
    int guard = 0;
    while (!(req_valid && req_ready) && guard < 100) begin @(negedge clk); guard++; end
    chk("R3", "req_index", 128'(req_index), 128'(cmd[5:0]));
    chk("R3", "req_arg", 128'(req_arg), 128'(arg));
    chk("R3", "req_resp_exp", 128'(req_resp_exp), 128'(cmd[6]));
    @(negedge clk);
    guard = 0;
    while (!rsp_ready && guard < 100) begin @(negedge clk); guard++; end
    rsp_valid = 1'b1; rsp_count = cnt; rsp_fail = fail; rsp_bytes = b;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_fail = 1'b0;
  endtask

  initial begin
    #(WD_CYCLES * 10);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 128'(busy), 128'(0));
    chk("R1", "req_valid", 128'(req_valid), 128'(0));
    chk("R1", "rsp_ready", 128'(rsp_ready), 128'(0));
    chk("R1", "status", 128'(status_q), 128'(0));
    chk("R1", "words", resp_words, '0);
    chk("R1", "cmd/arg", 128'({cmd_q, arg_q}), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [10:0]  c;
      logic [4:0]   cnt;
      logic         f;
      logic [7:0]   sd, es;
      logic [31:0]  a;
      logic [127:0] b;
      {c, cnt, f, sd, es} = VEC[i];
      a = {sd, ~sd, sd ^ 8'h5A, 8'(i)};
      b = make_bytes(sd);
      reg_wr(2'd2, 32'hFF);  // R12 clear all
      reg_wr(2'd0, a);       // R2
      reg_wr(2'd1, {21'd0, c});
      serve(c, a, cnt, f, b);
      if (es[6]) model_words = expect_words(b, cnt);
      chk(es[2] ? "R9" : (es[7] ? "R10" : (cnt == 5'd4 ? "R7" : "R8")), "status",
          128'(status_q), 128'(es));
      chk(es[6] ? (cnt == 5'd4 ? "R7" : "R8") : "R9", "words", resp_words, model_words);
      chk("R11", "busy/cmd", 128'({busy, cmd_q}), 128'({1'b0, c & 11'h3FF}));
    end

    // R2 plain write readback without enable
    reg_wr(2'd0, 32'hCAFE_F00D);
    reg_wr(2'd1, 32'h0C5);
    chk("R2", "arg_q", 128'(arg_q), 128'(32'hCAFE_F00D));
    chk("R2", "cmd_q", 128'(cmd_q), 128'(11'h0C5));
    chk("R2", "no request", 128'({busy, req_valid}), 128'(0));

    // R4 pending mode
    reg_wr(2'd1, 32'h6C5);
    chk("R4", "cmd_q", 128'(cmd_q), 128'(11'h2C5));
    repeat (3) @(negedge clk);
    chk("R4", "busy/req", 128'({busy, req_valid}), 128'(0));

    // R6 stray reply beat while idle
    reg_wr(2'd2, 32'hFF);
    rsp_valid = 1'b1; rsp_count = 5'd4; rsp_bytes = make_bytes(8'h99);
    repeat (2) @(negedge clk);
    rsp_valid = 1'b0;
    chk("R6", "status idle", 128'(status_q), 128'(0));
    chk("R6", "words idle", resp_words, model_words);

    // R3 back-pressure, R5 writes ignored while busy
    req_ready = 1'b0;
    reg_wr(2'd0, 32'h1234_5678);
    reg_wr(2'd1, 32'h441);
    repeat (3) @(negedge clk);
    chk("R3", "req held", 128'({busy, req_valid}), 128'(2'b11));
    chk("R6", "rsp_ready low", 128'(rsp_ready), 128'(0));
    reg_wr(2'd0, 32'hDEAD_BEEF);
    reg_wr(2'd1, 32'h4C2);
    chk("R5", "arg kept", 128'(req_arg), 128'(32'h1234_5678));
    chk("R5", "cmd kept", 128'(cmd_q), 128'(11'h441));
    req_ready = 1'b1;
    serve(11'h441, 32'h1234_5678, 5'd4, 1'b0, make_bytes(8'h3C));
    model_words = expect_words(make_bytes(8'h3C), 5'd4);
    chk("R7", "status", 128'(status_q), 128'(8'h40));
    chk("R7", "words", resp_words, model_words);

    // R12 sticky and partial clear
    reg_wr(2'd0, 32'h0);
    reg_wr(2'd1, 32'h40D);
    serve(11'h40D, 32'h0, 5'd0, 1'b0, '0);
    chk("R12", "sticky", 128'(status_q), 128'(8'hC0));
    reg_wr(2'd2, 32'h40);
    chk("R12", "partial clear", 128'(status_q), 128'(8'h80));
    reg_wr(2'd2, 32'hFF);
    chk("R12", "full clear", 128'(status_q), 128'(0));

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule